// File: doc/BRIEF.md
# Unique-Key Content-Addressable Memory

This block is a small associative store. It has a fixed number of entries, and each entry holds a valid flag, a key and a data word. On a lookup, the presented key is compared with every valid entry at the same time. The block then reports whether a match was found, the data word of the matching entry, and the index of that entry. The result is registered, so the answer appears one cycle after the request.

A separate modify port either stores a key/data pair or removes a key. A store first looks for the key among the existing entries. If the key is already present, the new data goes into the old entry's slot in that same cycle. This means a key can never be held twice, so at most one entry can ever match. If the key is new, an allocator picks the lowest-numbered empty slot. When there is no empty slot, the store is refused and a full indication is returned. The selection of the output word is built from AND-OR one-hot multiplexing rather than a shared bus.

A lookup and a modify may be issued in the same cycle. The lookup sees the contents as they were before the modify takes effect.

Top module: `ukcam_top`

## Requirements
- R1: After reset every entry is empty, and `srch_hit`, `srch_data`, `srch_idx`, `op_done` and `op_full` are all 0. A lookup issued right after reset misses.
- R2: A lookup (`srch_req`=1) whose key matches a valid entry gives `srch_hit`=1, that entry's data word and that entry's index on the cycle after the request.
- R3: When a lookup misses, or when no lookup is requested, `srch_hit`, `srch_data` and `srch_idx` are all 0 on the following cycle.
- R4: A store (`mod_req`=1, `mod_del`=0) of a key that is not present writes the pair into the lowest-index empty entry.
- R5: A store of a key that is already present replaces the data in that same entry's index. No second copy is made, so at most one valid entry ever holds a given key.
- R6: A removal (`mod_req`=1, `mod_del`=1) empties the entry holding the key. A removal of a key that is not present leaves all contents unchanged.
- R7: `op_done` is high for exactly the one cycle after each cycle with `mod_req`=1, and low otherwise.
- R8: A store of a new key while every entry is valid is refused. `op_full` is 1 together with `op_done`, and the contents do not change.
- R9: A lookup in the same cycle as a modify returns the result for the contents before that modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_req | input | 1 | Lookup request |
| srch_key | input | KEY_W | Lookup key |
| mod_req | input | 1 | Modify request |
| mod_del | input | 1 | 1 = remove, 0 = store |
| mod_key | input | KEY_W | Key to store or remove |
| mod_data | input | DATA_W | Data word to store |
| srch_hit | output | 1 | Lookup matched |
| srch_data | output | DATA_W | Data of matching entry, 0 on miss |
| srch_idx | output | IDX_W | Index of matching entry, 0 on miss |
| op_done | output | 1 | Modify completed (one cycle after request) |
| op_full | output | 1 | Store refused, no free entry |

## Verification
The memory is filled in order so that each new key's slot shows lowest-free allocation. Keys are then removed from the middle and re-stored, which tells lowest-index reuse apart from append-style placement. Stores of keys that are already present separate in-place replacement from duplication: the returned index must stay unchanged and only one entry may answer. A store attempted into a full array, a removal of an absent key, and lookups issued in the same cycle as a modify show refusal, absence of side effects and pre-update visibility. A long run of mixed operations over a narrow key range then exercises repeated collisions against the bench's behavioural array.

// File: rtl/ukcam_pkg.sv
package ukcam_pkg;
    typedef enum logic {
        MOD_STORE  = 1'b0,
        MOD_REMOVE = 1'b1
    } mod_kind_e;
endpackage

// File: rtl/ukcam_match.sv
module ukcam_match #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 8
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]              probe,
    output logic [ENTRIES-1:0]            hits
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hits[g] = valid[g] && (keys[g] == probe);
    end
endmodule

// File: rtl/ukcam_onehot_mux.sv
module ukcam_onehot_mux #(
    parameter int ENTRIES = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             sel,
    input  logic [ENTRIES-1:0][DATA_W-1:0] words,
    output logic [DATA_W-1:0]              word_o,
    output logic [IDX_W-1:0]               idx_o
);
    always_comb begin
        word_o = '0;
        idx_o  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            word_o = word_o | (words[i] & {DATA_W{sel[i]}});
            idx_o  = idx_o  | (IDX_W'(i) & {IDX_W{sel[i]}});
        end
    end
endmodule

// File: rtl/ukcam_alloc.sv
module ukcam_alloc #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid,
    output logic               any_free,
    output logic [IDX_W-1:0]   free_idx
);
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ukcam_top.sv
module ukcam_top
    import ukcam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srch_req,
    input  logic [KEY_W-1:0]  srch_key,
    input  logic              mod_req,
    input  logic              mod_del,
    input  logic [KEY_W-1:0]  mod_key,
    input  logic [DATA_W-1:0] mod_data,
    output logic              srch_hit,
    output logic [DATA_W-1:0] srch_data,
    output logic [IDX_W-1:0]  srch_idx,
    output logic              op_done,
    output logic              op_full
);
    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][KEY_W-1:0]  keys;
        logic [ENTRIES-1:0][DATA_W-1:0] data;
        logic                           hit;
        logic [DATA_W-1:0]              rdata;
        logic [IDX_W-1:0]               ridx;
        logic                           done;
        logic                           full;
    } cam_state_t;

    cam_state_t st_d, st_q;

    logic [ENTRIES-1:0] s_match;
    logic [ENTRIES-1:0] m_match;
    logic [DATA_W-1:0]  s_word;
    logic [IDX_W-1:0]   s_idx;
    logic [DATA_W-1:0]  m_word_unused;
    logic [IDX_W-1:0]   m_idx;
    logic               any_free;
    logic [IDX_W-1:0]   free_idx;
    mod_kind_e          kind;

    assign kind = mod_kind_e'(mod_del);

    ukcam_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_smatch (
        .valid(st_q.valid), .keys(st_q.keys), .probe(srch_key), .hits(s_match)
    );
    ukcam_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_mmatch (
        .valid(st_q.valid), .keys(st_q.keys), .probe(mod_key), .hits(m_match)
    );
    ukcam_onehot_mux #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_smux (
        .sel(s_match), .words(st_q.data), .word_o(s_word), .idx_o(s_idx)
    );
    ukcam_onehot_mux #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_mmux (
        .sel(m_match), .words(st_q.data), .word_o(m_word_unused), .idx_o(m_idx)
    );
    ukcam_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .valid(st_q.valid), .any_free(any_free), .free_idx(free_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.full = 1'b0;
        st_d.hit  = srch_req && (|s_match);
        st_d.rdata = st_d.hit ? s_word : '0;
        st_d.ridx  = st_d.hit ? s_idx  : '0;
        if (mod_req) begin
            st_d.done = 1'b1;
            if (kind == MOD_REMOVE) begin
                st_d.valid = st_q.valid & ~m_match;
            end else if (|m_match) begin
                st_d.data[m_idx] = mod_data;
            end else if (any_free) begin
                st_d.valid[free_idx] = 1'b1;
                st_d.keys[free_idx]  = mod_key;
                st_d.data[free_idx]  = mod_data;
            end else begin
                st_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign srch_hit  = st_q.hit;
    assign srch_data = st_q.rdata;
    assign srch_idx  = st_q.ridx;
    assign op_done   = st_q.done;
    assign op_full   = st_q.full;
endmodule

// File: rtl/ukcam_chk.sv
module ukcam_chk #(
    parameter int ENTRIES = 8,
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               srch_req,
    input logic               mod_req,
    input logic               srch_hit,
    input logic [DATA_W-1:0]  srch_data,
    input logic [IDX_W-1:0]   srch_idx,
    input logic               op_done,
    input logic               op_full,
    input logic [ENTRIES-1:0] s_match,
    input logic [ENTRIES-1:0] m_match
);
    assert_done_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mod_req |=> op_done);
    assert_no_stray_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_req |=> !op_done);
    assert_full_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_full |-> op_done);
    assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_hit |-> (srch_data == '0 && srch_idx == '0));
    assert_idle_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_req |=> !srch_hit);
    assert_unique_search_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_match));
    assert_unique_modify_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_match));
endmodule

bind ukcam_top ukcam_chk #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .srch_req(srch_req), .mod_req(mod_req),
    .srch_hit(srch_hit), .srch_data(srch_data), .srch_idx(srch_idx),
    .op_done(op_done), .op_full(op_full), .s_match(s_match), .m_match(m_match)
);

// File: tb/ukcam_top_bench.sv
module ukcam_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int KW = 8;
    localparam int DW = 16;
    localparam int IW = 3;

    logic clk = 0, rst_n = 0;
    logic srch_req = 0, mod_req = 0, mod_del = 0;
    logic [KW-1:0] srch_key = 0, mod_key = 0;
    logic [DW-1:0] mod_data = 0;
    logic srch_hit, op_done, op_full;
    logic [DW-1:0] srch_data;
    logic [IW-1:0] srch_idx;

    int checks = 0, fails = 0, cycles = 0;
    bit finished = 0;

    // behavioural reference array
    bit      m_valid [N];
    int      m_key   [N];
    int      m_data  [N];

    ukcam_top u_ukcam_top (
        .clk(clk), .rst_n(rst_n), .srch_req(srch_req), .srch_key(srch_key),
        .mod_req(mod_req), .mod_del(mod_del), .mod_key(mod_key), .mod_data(mod_data),
        .srch_hit(srch_hit), .srch_data(srch_data), .srch_idx(srch_idx),
        .op_done(op_done), .op_full(op_full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles++;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int find_key(int k);
        int hits = 0, at = -1;
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_key[i] == k) begin hits++; at = i; end
        if (hits > 1) at = -2;
        return at;
    endfunction

    // one cycle: drive at negedge, expect results at next negedge
    task automatic step(bit s, int sk, bit m, bit d, int mk, int md, string tag);
        int e_hit, e_data, e_idx, e_done, e_full, at;
        srch_req = s; srch_key = KW'(sk);
        mod_req = m; mod_del = d; mod_key = KW'(mk); mod_data = DW'(md);
        at = find_key(sk);
        check({tag, " R5 unique"}, (at == -2) ? 1 : 0, 0);
        e_hit  = (s && at >= 0) ? 1 : 0;
        e_data = e_hit ? m_data[at] : 0;
        e_idx  = e_hit ? at : 0;
        e_done = m ? 1 : 0;
        e_full = 0;
        if (m) begin
            int mi = find_key(mk);
            if (d) begin
                if (mi >= 0) m_valid[mi] = 0;
            end else if (mi >= 0) begin
                m_data[mi] = md & 16'hFFFF;
            end else begin
                int fr = -1;
                for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) fr = i;
                if (fr < 0) e_full = 1;
                else begin m_valid[fr] = 1; m_key[fr] = mk & 8'hFF; m_data[fr] = md & 16'hFFFF; end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " R2/R3 hit"},  srch_hit,  e_hit);
        check({tag, " R2/R3 data"}, srch_data, e_data);
        check({tag, " R2/R4/R5 idx"}, srch_idx, e_idx);
        check({tag, " R7 done"},    op_done,   e_done);
        check({tag, " R8 full"},    op_full,   e_full);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        wait (cycles > 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_key[i] = 0; m_data[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 hit",  srch_hit, 0);
        check("R1 done", op_done, 0);
        check("R1 full", op_full, 0);
        check("R1 data", srch_data, 0);
        rst_n = 1;
        step(1, 8'h00, 0, 0, 0, 0, "R1 post-reset lookup");
        // fill in order: R4
        for (int i = 0; i < N; i++) step(0, 0, 1, 0, 8'h10 + i, 16'h100 + i, "R4 fill");
        for (int i = 0; i < N; i++) step(1, 8'h10 + i, 0, 0, 0, 0, "R2 readback");
        // replace existing: R5
        step(0, 0, 1, 0, 8'h13, 16'hBEEF, "R5 replace");
        step(1, 8'h13, 0, 0, 0, 0, "R5 same slot");
        // full array: R8
        step(0, 0, 1, 0, 8'h77, 16'h7777, "R8 refuse");
        step(1, 8'h77, 0, 0, 0, 0, "R8 not stored");
        // removals: R6
        step(0, 0, 1, 1, 8'h15, 0, "R6 remove");
        step(0, 0, 1, 1, 8'h12, 0, "R6 remove");
        step(1, 8'h15, 0, 0, 0, 0, "R6 gone");
        step(0, 0, 1, 1, 8'h99, 0, "R6 absent");
        for (int i = 0; i < N; i++) step(1, 8'h10 + i, 0, 0, 0, 0, "R6 untouched");
        // reuse lowest hole: R4
        step(0, 0, 1, 0, 8'h40, 16'h4040, "R4 lowest hole");
        step(1, 8'h40, 0, 0, 0, 0, "R4 hole idx");
        // same-cycle visibility: R9
        step(1, 8'h41, 1, 0, 8'h41, 16'h4141, "R9 pre-store");
        step(1, 8'h41, 1, 1, 8'h41, 0, "R9 pre-remove");
        step(1, 8'h41, 0, 0, 0, 0, "R9 after");
        // mixed traffic over a narrow key range
        for (int n = 0; n < 1500; n++) begin
            int r = $urandom;
            step(r[0], (r >> 4) & 15, r[1], r[2] & r[3], (r >> 8) & 15, (r >> 12) & 16'hFFFF, "mix R2 R5 R6 R8");
        end
        step(0, 0, 0, 0, 0, 0, "R7 idle");
        finish_run();
    end
endmodule